// File: doc/BRIEF.md
# Flash In-System Programming Controller

This block sits between an on-chip processor (or a boot routine running from ROM) and a byte-addressed flash program array. Software loads a 16-bit target address through two byte-wide address registers, puts a data byte and a pulse length into their own registers, and then writes an operation code into a privileged control register. The controller drives the array-side address, data and command lines. For program and erase it holds them steady for a counted pulse while a busy flag is high. For a read it returns the addressed byte in a read-data register one cycle later.

The controller protects an operation in flight. While a pulse runs, writes to the address, data and timing registers and any new operation code are refused, and a sticky error flag is set. The same flag is set by a zero pulse length and by a whole-array erase whose address is not zero. A read of the option word is requested at address 0xFFFF and is steered to the word's physical location 0x7FFF. A stored boot-select bit decides where the processor starts after reset. When the bit is 0, its erased value, the start is at the base of a 1 KB boot ROM. When it is 1, the start is at flash address 0x0000. The bit is sampled only when reset is released or when an exit operation is issued.

The register bus is a plain single-cycle interface. A write takes effect at the clock edge where the write enable is high. Read data is combinational while the read enable is high and is zero otherwise. There is no back-pressure: software polls the busy bit of the control register.

Top module: `flash_isp_ctrl`

## Requirements
- R1: After reset, the registers read back as follows: address-high (bus address 0) is 0x00, address-low (1) is 0x00, read-data (2) is 0x00, write-data (3) is 0x00 and timing (4) is 0x00. The busy flag is 0 and the error flag is 0.
- R2: The array address equals {address-high, address-low}, with address-high supplying bits 15..8.
- R3: Writing operation code 1 (read) to control register 5 drives array command 1 for exactly one cycle. The array byte is captured into read-data at the next edge. A target of 0xFFFF is presented to the array as 0x7FFF.
- R4: Operation code 2 (program) drives array command 2 with the write-data byte on the array data lines. Busy stays high for exactly as many cycles as the timing register holds.
- R5: A program or erase operation issued while the timing register is 0 is not started: no array command and no busy. The error flag is set.
- R6: Operation code 3 (page erase) drives array command 3. The array address during the pulse has its low log2(PAGE_BYTES) bits cleared, which is 6 bits for the default of 64 bytes.
- R7: Operation code 4 (mass erase) starts, as array command 4 with address 0, only when both address registers are 0. Otherwise the array is left untouched and the error flag is set.
- R8: While busy, writes to registers 0, 1, 3 and 4 and any operation code are ignored, and the error flag is set. The array address stays stable for the whole pulse.
- R9: The control register answers only when the privilege input is high. An unprivileged write to it has no effect, and an unprivileged read of it returns 0. Control read layout: bit 0 is busy, bit 1 is the error flag, bit 2 is the boot-from-ROM flag.
- R10: When reset is released, boot-select 0 gives boot-from-ROM 1 and a start vector equal to the ROM base (0xFC00 by default). Boot-select 1 gives boot-from-ROM 0 and a start vector of 0x0000.
- R11: A change of the boot-select input has no effect until the next reset or until a privileged control write with bit 5 (exit) set.
- R12: The error flag stays set until a privileged control write with bit 6 set clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 8 | Register write data |
| bus_we | input | 1 | Register write enable |
| bus_re | input | 1 | Register read enable |
| bus_priv | input | 1 | Privileged access; gates the control register |
| bus_rdata | output | 8 | Register read data (0 when not reading) |
| fl_addr | output | 16 | Array address |
| fl_wdata | output | 8 | Array program data |
| fl_cmd | output | 3 | Array command: 0 idle, 1 read, 2 program, 3 page erase, 4 mass erase |
| fl_rdata | input | 8 | Array read data for the presented address |
| fl_busy | output | 1 | Program/erase pulse in progress |
| opt_boot | input | 1 | Stored boot-select bit from the option word |
| boot_rom | output | 1 | Start in boot ROM |
| start_vec | output | 16 | Reset start address |

## Verification
An address register that is overwritten during a pulse shows up on fl_addr in the next cycle. It also shows up later as a byte read back from the wrong location. A pulse counter that is off by one makes busy one cycle too short or too long, which the bench measures edge by edge. A lost or stuck error flag is visible in the control readback as soon as the refused access has been made. A boot-select latch that follows its input too early changes start_vec within one cycle of the input change, before any reset or exit operation.

// File: rtl/isp_pkg.sv
package isp_pkg;
  // register select codes
  localparam logic [2:0] RS_ADR_HI = 3'd0;
  localparam logic [2:0] RS_ADR_LO = 3'd1;
  localparam logic [2:0] RS_RDATA  = 3'd2;
  localparam logic [2:0] RS_WDATA  = 3'd3;
  localparam logic [2:0] RS_TIMING = 3'd4;
  localparam logic [2:0] RS_CTRL   = 3'd5;
  // array command codes (also the control operation codes)
  localparam logic [2:0] OP_IDLE = 3'd0;
  localparam logic [2:0] OP_READ = 3'd1;
  localparam logic [2:0] OP_PROG = 3'd2;
  localparam logic [2:0] OP_PAGE = 3'd3;
  localparam logic [2:0] OP_MASS = 3'd4;
  // control write bits
  localparam int CB_EXIT = 5;
  localparam int CB_CLR  = 6;
endpackage

// File: rtl/isp_pulse_timer.sv
module isp_pulse_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] len,
  output logic          busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (start) begin
      cnt  <= len;
      busy <= 1'b1;
    end else if (busy) begin
      if (cnt == CW'(1)) busy <= 1'b0;
      cnt <= cnt - CW'(1);
    end
  end

  // R4
  load_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  // R4
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/isp_boot_sel.sv
module isp_boot_sel #(
  parameter int          AW       = 16,
  parameter logic [15:0] ROM_BASE = 16'hFC00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exit_req,
  input  logic          opt_boot,
  output logic          boot_rom,
  output logic [AW-1:0] start_vec
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_rom <= 1'b1;
      armed    <= 1'b1;
    end else if (armed || exit_req) begin
      boot_rom <= !opt_boot;
      armed    <= 1'b0;
    end
  end

  assign start_vec = boot_rom ? AW'(ROM_BASE) : '0;

  // R11
  boot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!armed) && $past(!exit_req)) |-> $stable(boot_rom));
endmodule

// File: rtl/flash_isp_ctrl.sv
module flash_isp_ctrl
  import isp_pkg::*;
#(
  parameter int          DW         = 8,
  parameter int          PAGE_BYTES = 64,
  parameter logic [15:0] ROM_BASE   = 16'hFC00,
  parameter logic [15:0] OPT_ALIAS  = 16'hFFFF,
  parameter logic [15:0] OPT_PHYS   = 16'h7FFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic            bus_we,
  input  logic            bus_re,
  input  logic            bus_priv,
  output logic [DW-1:0]   bus_rdata,
  output logic [2*DW-1:0] fl_addr,
  output logic [DW-1:0]   fl_wdata,
  output logic [2:0]      fl_cmd,
  input  logic [DW-1:0]   fl_rdata,
  output logic            fl_busy,
  input  logic            opt_boot,
  output logic            boot_rom,
  output logic [2*DW-1:0] start_vec
);
  localparam int AW      = 2 * DW;
  localparam int PG_BITS = $clog2(PAGE_BYTES);

  logic [DW-1:0] adr_hi, adr_lo, rd_q, wr_q, tim_q;
  logic [2:0]    op_q;
  logic          err_q, rd_pend, busy;
  logic [AW-1:0] tgt;
  logic          data_wr, ctrl_wr, cmd_valid, timed, busy_hit, reject, start, rd_go, exit_req;
  logic [2:0]    req_op;

  assign tgt     = {adr_hi, adr_lo};
  assign data_wr = bus_we && (bus_addr == RS_ADR_HI || bus_addr == RS_ADR_LO ||
                              bus_addr == RS_WDATA  || bus_addr == RS_TIMING);
  assign ctrl_wr   = bus_we && bus_priv && (bus_addr == RS_CTRL);
  assign req_op    = bus_wdata[2:0];
  assign cmd_valid = ctrl_wr && (req_op >= OP_READ) && (req_op <= OP_MASS);
  assign timed     = (req_op == OP_PROG) || (req_op == OP_PAGE) || (req_op == OP_MASS);
  assign busy_hit  = busy && (data_wr || cmd_valid);
  assign reject    = cmd_valid && !busy && timed &&
                     ((tim_q == '0) || (req_op == OP_MASS && tgt != '0));
  assign start     = cmd_valid && !busy && timed && !reject;
  assign rd_go     = cmd_valid && !busy && (req_op == OP_READ);
  assign exit_req  = ctrl_wr && bus_wdata[CB_EXIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adr_hi  <= '0;
      adr_lo  <= '0;
      rd_q    <= '0;
      wr_q    <= '0;
      tim_q   <= '0;
      op_q    <= OP_IDLE;
      err_q   <= 1'b0;
      rd_pend <= 1'b0;
    end else begin
      if (data_wr && !busy) begin
        case (bus_addr)
          RS_ADR_HI: adr_hi <= bus_wdata;
          RS_ADR_LO: adr_lo <= bus_wdata;
          RS_WDATA:  wr_q   <= bus_wdata;
          RS_TIMING: tim_q  <= bus_wdata;
          default: ;
        endcase
      end
      if (start) op_q <= req_op;
      rd_pend <= rd_go;
      if (rd_pend) rd_q <= fl_rdata;
      if (busy_hit || reject) err_q <= 1'b1;
      else if (ctrl_wr && bus_wdata[CB_CLR]) err_q <= 1'b0;
    end
  end

  isp_pulse_timer #(.CW(DW)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .len(tim_q), .busy(busy)
  );

  isp_boot_sel #(.AW(AW), .ROM_BASE(ROM_BASE)) u_boot (
    .clk(clk), .rst_n(rst_n), .exit_req(exit_req), .opt_boot(opt_boot),
    .boot_rom(boot_rom), .start_vec(start_vec)
  );

  always_comb begin
    if (busy && op_q == OP_PAGE)
      fl_addr = {tgt[AW-1:PG_BITS], {PG_BITS{1'b0}}};
    else if (rd_pend && tgt == AW'(OPT_ALIAS))
      fl_addr = AW'(OPT_PHYS);
    else
      fl_addr = tgt;
  end

  assign fl_cmd   = busy ? op_q : (rd_pend ? OP_READ : OP_IDLE);
  assign fl_wdata = wr_q;
  assign fl_busy  = busy;

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      case (bus_addr)
        RS_ADR_HI: bus_rdata = adr_hi;
        RS_ADR_LO: bus_rdata = adr_lo;
        RS_RDATA:  bus_rdata = rd_q;
        RS_WDATA:  bus_rdata = wr_q;
        RS_TIMING: bus_rdata = tim_q;
        RS_CTRL:   bus_rdata = bus_priv ? {{(DW-3){1'b0}}, boot_rom, err_q, busy} : '0;
        default:   bus_rdata = '0;
      endcase
    end
  end

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_busy && $past(fl_busy)) |-> $stable(fl_addr));
  // R7
  mass_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_cmd == OP_MASS) |-> (fl_addr == '0));
  // R5
  no_zero_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_busy) |-> ($past(tim_q) != '0));
  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_q) && !($past(ctrl_wr) && $past(bus_wdata[CB_CLR]))) |-> err_q);
endmodule

// File: tb/flash_isp_ctrl_test.sv
module flash_isp_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata, fl_wdata, fl_rdata;
  logic bus_we = 1'b0, bus_re = 1'b0, bus_priv = 1'b1;
  logic [15:0] fl_addr, start_vec;
  logic [2:0] fl_cmd;
  logic fl_busy, boot_rom, opt_boot = 1'b0;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [7:0] fmem [256];
  logic [7:0] shadow [256];
  logic [7:0] opt_word = 8'hA5;
  int mass_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_isp_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_priv(bus_priv), .bus_rdata(bus_rdata),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_cmd(fl_cmd), .fl_rdata(fl_rdata),
    .fl_busy(fl_busy), .opt_boot(opt_boot), .boot_rom(boot_rom), .start_vec(start_vec)
  );

  // array model
  assign fl_rdata = (fl_addr == 16'h7FFF) ? opt_word : fmem[fl_addr[7:0]];
  always @(posedge clk) begin
    if (fl_cmd == 3'd2) fmem[fl_addr[7:0]] <= fl_wdata;
    else if (fl_cmd == 3'd3)
      for (int i = 0; i < 64; i++) fmem[{fl_addr[7:6], 6'(i)}] <= 8'hFF;
    else if (fl_cmd == 3'd4) begin
      for (int i = 0; i < 256; i++) fmem[i] <= 8'hFF;
      mass_seen <= mass_seen + 1;
    end
  end

  function automatic logic [15:0] page_base(input logic [15:0] a);
    return a & 16'hFFC0;
  endfunction
  function automatic logic [7:0] ctrl_word(input bit rom, input bit err, input bit bsy);
    return {5'b0, rom, err, bsy};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d, input bit p = 1'b1);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_priv = p; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_priv = 1'b1;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] v, input bit p = 1'b1);
    bus_addr = a; bus_priv = p; bus_re = 1'b1;
    #1 v = bus_rdata;
    bus_re = 1'b0; bus_priv = 1'b1;
  endtask

  logic [15:0] cap_addr;
  logic [2:0]  cap_cmd;
  logic [7:0]  cap_wd;

  task automatic run_op(input logic [7:0] code, output int n);
    bus_wr(3'd5, code);
    cap_addr = fl_addr; cap_cmd = fl_cmd; cap_wd = fl_wdata;
    n = 0;
    while (fl_busy) begin n++; @(negedge clk); end
  endtask

  task automatic read_at(input logic [15:0] a, output logic [7:0] v);
    bus_wr(3'd0, a[15:8]);
    bus_wr(3'd1, a[7:0]);
    bus_wr(3'd5, 8'd1);
    cap_addr = fl_addr; cap_cmd = fl_cmd;
    @(negedge clk);
    bus_rd(3'd2, v);
  endtask

  task automatic set_target(input logic [15:0] a, input logic [7:0] d, input logic [7:0] t);
    bus_wr(3'd0, a[15:8]);
    bus_wr(3'd1, a[7:0]);
    bus_wr(3'd3, d);
    bus_wr(3'd4, t);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) begin fmem[i] = 8'hFF; shadow[i] = 8'hFF; end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    for (int r = 0; r < 5; r++) begin
      bus_rd(3'(r), v);
      chk(v == 8'h00, "R1 reg reset", v, 0);
    end
    bus_rd(3'd5, v);
    chk(v == ctrl_word(1, 0, 0), "R1/R9 ctrl reset", v, ctrl_word(1, 0, 0));
    // R10 erased boot-select -> ROM
    chk(boot_rom == 1'b1 && start_vec == 16'hFC00, "R10 boot rom", start_vec, 16'hFC00);

    // R4 / R2 directed program
    set_target(16'h1234, 8'h5A, 8'd3);
    run_op(8'd2, n);
    chk(n == 3, "R4 busy length", n, 3);
    chk(cap_cmd == 3'd2 && cap_wd == 8'h5A, "R4 cmd/data", {cap_cmd, cap_wd}, {3'd2, 8'h5A});
    chk(cap_addr == 16'h1234, "R2 address concat", cap_addr, 16'h1234);
    shadow[8'h34] = 8'h5A;

    // R3 read back and one-cycle command
    read_at(16'h1234, v);
    chk(cap_cmd == 3'd1, "R3 read cmd", cap_cmd, 1);
    chk(v == 8'h5A, "R3 read data", v, 8'h5A);
    chk(fl_cmd == 3'd0, "R3 read one cycle", fl_cmd, 0);

    // R3 option alias
    read_at(16'hFFFF, v);
    chk(cap_addr == 16'h7FFF, "R3 alias address", cap_addr, 16'h7FFF);
    chk(v == 8'hA5, "R3 option data", v, 8'hA5);

    // R8 writes during busy ignored, error set
    set_target(16'h0210, 8'h11, 8'd10);
    bus_wr(3'd5, 8'd2);
    bus_wr(3'd1, 8'h99);
    bus_wr(3'd3, 8'h77);
    chk(fl_addr == 16'h0210 && fl_busy, "R8 addr held", fl_addr, 16'h0210);
    while (fl_busy) @(negedge clk);
    shadow[8'h10] = 8'h11;
    bus_rd(3'd1, v);
    chk(v == 8'h10, "R8 addr-lo unchanged", v, 8'h10);
    bus_rd(3'd3, v);
    chk(v == 8'h11, "R8 wdata unchanged", v, 8'h11);
    bus_rd(3'd5, v);
    chk(v == ctrl_word(1, 1, 0), "R8 error set", v, ctrl_word(1, 1, 0));

    // R12 sticky until clear
    repeat (4) @(negedge clk);
    bus_rd(3'd5, v);
    chk(v[1] == 1'b1, "R12 error sticky", v[1], 1);
    bus_wr(3'd5, 8'h40);
    bus_rd(3'd5, v);
    chk(v[1] == 1'b0, "R12 error cleared", v[1], 0);

    // R5 zero timing rejected
    set_target(16'h0020, 8'h33, 8'd0);
    run_op(8'd2, n);
    chk(n == 0 && cap_cmd == 3'd0, "R5 not started", n, 0);
    bus_rd(3'd5, v);
    chk(v[1] == 1'b1, "R5 error set", v[1], 1);
    read_at(16'h0020, v);
    chk(v == shadow[8'h20], "R5 array untouched", v, shadow[8'h20]);
    bus_wr(3'd5, 8'h40);

    // R9 unprivileged control
    set_target(16'h0030, 8'h44, 8'd2);
    bus_wr(3'd5, 8'd2, 1'b0);
    chk(fl_busy == 1'b0 && fl_cmd == 3'd0, "R9 unpriv write ignored", fl_cmd, 0);
    bus_rd(3'd5, v, 1'b0);
    chk(v == 8'h00, "R9 unpriv read zero", v, 0);

    // R6 page erase
    set_target(16'h1245, 8'h66, 8'd2);
    run_op(8'd2, n);
    shadow[8'h45] = 8'h66;
    bus_wr(3'd1, 8'h57);
    run_op(8'd3, n);
    chk(cap_cmd == 3'd3 && cap_addr == page_base(16'h1257), "R6 page base", cap_addr, page_base(16'h1257));
    chk(n == 2, "R6 pulse length", n, 2);
    for (int i = 64; i < 128; i++) shadow[i] = 8'hFF;
    read_at(16'h1245, v);
    chk(v == 8'hFF, "R6 byte erased", v, 8'hFF);

    // R7 mass erase with nonzero address
    n = mass_seen;
    read_at(16'h1234, v);
    run_op(8'd4, n);
    chk(n == 0 && cap_cmd == 3'd0, "R7 nonzero refused", cap_cmd, 0);
    bus_rd(3'd5, v);
    chk(v[1] == 1'b1, "R7 error set", v[1], 1);
    read_at(16'h1234, v);
    chk(v == 8'h5A, "R7 array untouched", v, 8'h5A);
    bus_wr(3'd5, 8'h40);

    // R2/R4 constrained random program + readback
    for (int k = 0; k < 30; k++) begin
      logic [15:0] a;
      logic [7:0] d, t;
      a = {8'($urandom % 127), 8'($urandom)};
      d = 8'($urandom);
      t = 8'(1 + $urandom % 6);
      set_target(a, d, t);
      run_op(8'd2, n);
      chk(n == int'(t), "R4 random busy", n, t);
      chk(cap_addr == a && cap_wd == d, "R2 random addr", cap_addr, a);
      shadow[a[7:0]] = d;
      read_at(a, v);
      chk(v == shadow[a[7:0]], "R3 random readback", v, shadow[a[7:0]]);
    end

    // R7 mass erase at zero
    set_target(16'h0000, 8'h00, 8'd2);
    run_op(8'd4, n);
    chk(cap_cmd == 3'd4 && n == 2, "R7 mass erase runs", cap_cmd, 4);
    read_at(16'h0010, v);
    chk(v == 8'hFF, "R7 erased", v, 8'hFF);

    // R11 boot-select change waits for exit
    opt_boot = 1'b1;
    repeat (3) @(negedge clk);
    chk(boot_rom == 1'b1 && start_vec == 16'hFC00, "R11 no early change", start_vec, 16'hFC00);
    bus_wr(3'd5, 8'h20);
    chk(boot_rom == 1'b0 && start_vec == 16'h0000, "R11 exit applies", start_vec, 0);
    opt_boot = 1'b0;
    @(negedge clk);
    chk(boot_rom == 1'b0, "R11 held after exit", boot_rom, 0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(boot_rom == 1'b1 && start_vec == 16'hFC00, "R10 reset reloads", start_vec, 16'hFC00);
    bus_rd(3'd0, v);
    chk(v == 8'h00, "R1 addr cleared by reset", v, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule